// File: doc/BRIEF.md
# Charger Fault and Status Reporter

This block supervises a battery charger at the digital level. It reads comparator flags that are already synchronized to its clock: input undervoltage, input in a valid range, input overvoltage with a hysteretic release, battery above its regulation target, PWM pulse activity and a charging-active indication. From these flags it decides whether charging may run and whether the input switch may conduct. It also keeps a two-bit status field and a three-bit fault code.

Each class of fault writes its own code and has its own way out. An input-low fault holds charging off until a restart interval has elapsed and the input is valid again. An input overvoltage opens the input switch until the overvoltage flag drops and the input is valid. A battery overvoltage with no PWM activity for a timeout only reports the fault, and that report clears as soon as PWM activity returns.

A status pin with an open-drain output is modelled as a pull-low enable, gated by a pin-enable input. While charging is in progress the pin is pulled low. On every fault event it is pulled low for a fixed number of cycles and then released.

Top module: `chgsup_top`

## Requirements
- R1: While charging is enabled, `chg_active_i` is high, `vin_low_i` is high and `vin_ovp_i` is low at a clock edge, `chg_en_o` goes low after that edge. `fault_o` becomes 3'b011 and `stat_o` becomes 2'b11.
- R2: After an input-low fault is entered, `chg_en_o` goes high again at the first edge that lies at least RESTART_CYC+1 edges after entry and at which `vin_ok_i` is high. With `vin_ok_i` high throughout, this is exactly edge RESTART_CYC+1.
- R3: `vin_ovp_i` high at an edge, in any state, drives `in_sw_en_o` and `chg_en_o` low after that edge. `fault_o` becomes 3'b001 and `stat_o` becomes 2'b11.
- R4: An overvoltage fault holds until an edge at which `vin_ovp_i` is low and `vin_ok_i` is high. After that edge `in_sw_en_o` and `chg_en_o` return high.
- R5: After BAT_TMO consecutive edges with `bat_ovp_i` high and `pwm_pulse_i` low, `fault_o` becomes 3'b100 and `stat_o` becomes 2'b11. Any edge with `pwm_pulse_i` high restarts the count. The 2'b11 status clears at the first edge with `pwm_pulse_i` high or `bat_ovp_i` low. Charging enable is not affected.
- R6: With `stat_en_i` low, `stat_pull_o` is low at all times.
- R7: With no fault and no fault pulse, `stat_o` is 2'b01 when `chg_active_i` is high and 2'b00 otherwise. With `stat_en_i` high, `stat_pull_o` follows `chg_active_i` in that condition.
- R8: A fault event with `stat_en_i` high makes `stat_pull_o` high for exactly PULSE_CYC cycles after the event edge. The pin is then released even while the fault persists.
- R9: A fault event during an active pulse restarts the pulse and overwrites `fault_o` with the new code.
- R10: When `vin_ovp_i` and `vin_low_i` are both high at the same edge, the overvoltage code 3'b001 is recorded and the input switch opens.
- R11: After reset, `chg_en_o` and `in_sw_en_o` are high, `fault_o` is 3'b000 and `stat_pull_o` is low.
- R12: `vin_low_i` is ignored when `chg_active_i` is low or when a fault is already held. In that case `chg_en_o` stays unchanged and no new fault pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_en_i | input | 1 | Enables the status pin driver |
| chg_active_i | input | 1 | Charging process is running |
| vin_low_i | input | 1 | Input below the falling minimum threshold |
| vin_ok_i | input | 1 | Input above the rising minimum threshold |
| vin_ovp_i | input | 1 | Input overvoltage, drops at the hysteresis level |
| bat_ovp_i | input | 1 | Battery above its regulation target |
| pwm_pulse_i | input | 1 | A PWM pulse occurred this cycle |
| stat_o | output | 2 | Status field: 00 idle, 01 charging, 11 fault |
| fault_o | output | 3 | Most recent fault code |
| stat_pull_o | output | 1 | 1 pulls the open-drain status pin low |
| chg_en_o | output | 1 | Charging allowed |
| in_sw_en_o | output | 1 | Input switch allowed to conduct |

## Verification
The bench builds the block with RESTART_CYC=6, BAT_TMO=5 and PULSE_CYC=4. With these values every timer boundary is only a few cycles away. The bench sweeps each cycle across the pulse window and the restart window, and it checks the cycles just before and just at the battery timeout, including the timeout restarted by a PWM pulse. The short values also let faults overlap an active pulse, so the pulse restart and the code overwrite can be seen at the ports.

// File: rtl/chgsup_pkg.sv
package chgsup_pkg;

   typedef enum logic [1:0] {
      ST_RUN = 2'd0,
      ST_UVW = 2'd1,
      ST_OVH = 2'd2
   } sup_state_e;

   localparam logic [2:0] FLT_NONE   = 3'b000;
   localparam logic [2:0] FLT_IN_OV  = 3'b001;
   localparam logic [2:0] FLT_IN_LOW = 3'b011;
   localparam logic [2:0] FLT_BAT_OV = 3'b100;

   localparam logic [1:0] STS_IDLE  = 2'b00;
   localparam logic [1:0] STS_CHG   = 2'b01;
   localparam logic [1:0] STS_FAULT = 2'b11;

endpackage

// File: rtl/chgsup_satcnt.sv
module chgsup_satcnt #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic full_o,
   output logic step_o
);
   localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [W-1:0] TOP  = W'(LIMIT);
   localparam logic [W-1:0] PREV = W'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("chgsup_satcnt: LIMIT must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != TOP)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign full_o = (cnt_q == TOP);
   assign step_o = inc_i && !clr_i && (cnt_q == PREV);
endmodule

// File: rtl/chgsup_pulse.sv
module chgsup_pulse #(
   parameter int WIDTH_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic act_o
);
   localparam int W = (WIDTH_CYC < 2) ? 1 : $clog2(WIDTH_CYC + 1);
   localparam logic [W-1:0] LOADV = W'(WIDTH_CYC);

   generate
      if (WIDTH_CYC < 1) begin : g_bad_width
         $error("chgsup_pulse: WIDTH_CYC must be at least 1");
      end
   endgenerate

   logic [W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load_i) begin
         rem_q <= LOADV;
      end else if (rem_q != '0) begin
         rem_q <= rem_q - 1'b1;
      end
   end

   assign act_o = (rem_q != '0);
endmodule

// File: rtl/chgsup_top.sv
module chgsup_top
   import chgsup_pkg::*;
#(
   parameter int RESTART_CYC = 2_000_000,
   parameter int BAT_TMO     = 30_000,
   parameter int PULSE_CYC   = 128_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stat_en_i,
   input  logic       chg_active_i,
   input  logic       vin_low_i,
   input  logic       vin_ok_i,
   input  logic       vin_ovp_i,
   input  logic       bat_ovp_i,
   input  logic       pwm_pulse_i,
   output logic [1:0] stat_o,
   output logic [2:0] fault_o,
   output logic       stat_pull_o,
   output logic       chg_en_o,
   output logic       in_sw_en_o
);

   sup_state_e state_q, state_d;
   logic [2:0] fault_q, fault_d;
   logic       ov_ev, uv_ev, bat_ev, any_ev;
   logic       rst_full, unused_rst_step;
   logic       bat_held, pulse_act;

   // restart interval after an input-low fault
   chgsup_satcnt #(.LIMIT(RESTART_CYC)) u_restart (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q != ST_UVW),
      .inc_i  (state_q == ST_UVW),
      .full_o (rst_full),
      .step_o (unused_rst_step)
   );

   // battery-overvoltage quiet-PWM timeout; saturated count = fault held
   chgsup_satcnt #(.LIMIT(BAT_TMO)) u_quiet (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (!bat_ovp_i || pwm_pulse_i),
      .inc_i  (1'b1),
      .full_o (bat_held),
      .step_o (bat_ev)
   );

   chgsup_pulse #(.WIDTH_CYC(PULSE_CYC)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (any_ev),
      .act_o  (pulse_act)
   );

   always_comb begin
      ov_ev  = vin_ovp_i && (state_q != ST_OVH);
      uv_ev  = !vin_ovp_i && (state_q == ST_RUN) && chg_active_i && vin_low_i;
      any_ev = ov_ev || uv_ev || bat_ev;

      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (vin_ovp_i)  state_d = ST_OVH;
            else if (uv_ev) state_d = ST_UVW;
         end
         ST_UVW: begin
            if (vin_ovp_i)                 state_d = ST_OVH;
            else if (rst_full && vin_ok_i) state_d = ST_RUN;
         end
         ST_OVH: begin
            if (!vin_ovp_i && vin_ok_i) state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase

      if (ov_ev)       fault_d = FLT_IN_OV;
      else if (uv_ev)  fault_d = FLT_IN_LOW;
      else if (bat_ev) fault_d = FLT_BAT_OV;
      else             fault_d = fault_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         fault_q <= FLT_NONE;
      end else begin
         state_q <= state_d;
         fault_q <= fault_d;
      end
   end

   always_comb begin
      if ((state_q != ST_RUN) || bat_held) stat_o = STS_FAULT;
      else if (chg_active_i)               stat_o = STS_CHG;
      else                                 stat_o = STS_IDLE;
   end

   assign fault_o     = fault_q;
   assign chg_en_o    = (state_q == ST_RUN);
   assign in_sw_en_o  = (state_q != ST_OVH);
   assign stat_pull_o = stat_en_i && (pulse_act || (stat_o == STS_CHG));

endmodule

// File: rtl/chgsup_chk.sv
module chgsup_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stat_en_i,
   input logic       chg_active_i,
   input logic       vin_low_i,
   input logic       vin_ovp_i,
   input logic [1:0] stat_o,
   input logic [2:0] fault_o,
   input logic       stat_pull_o,
   input logic       chg_en_o,
   input logic       in_sw_en_o
);
   AST_UV_STOPS_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_en_o && chg_active_i && vin_low_i && !vin_ovp_i) |=> (!chg_en_o && fault_o == 3'b011 && stat_o == 2'b11)); // R1

   AST_UV_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(chg_en_o) && fault_o == 3'b011) |=> !chg_en_o); // R2

   AST_OV_OPENS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      vin_ovp_i |=> (!in_sw_en_o && !chg_en_o && fault_o == 3'b001 && stat_o == 2'b11)); // R3

   AST_OV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_sw_en_o && vin_ovp_i) |=> !in_sw_en_o); // R4

   AST_PIN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_en_i |-> !stat_pull_o); // R6

   AST_OV_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (vin_ovp_i && in_sw_en_o) |=> (!stat_en_i || stat_pull_o)); // R8

   AST_OV_BEATS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (vin_ovp_i && vin_low_i) |=> (fault_o == 3'b001)); // R10

   AST_SWITCH_GATES_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_sw_en_o |-> !chg_en_o); // R3
endmodule

bind chgsup_top chgsup_chk u_chk (.*);

// File: tb/chgsup_top_test.sv
module chgsup_top_test;
   localparam int CLK_PER = 10;
   localparam int RST = 6;
   localparam int TMO = 5;
   localparam int PUL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stat_en_i = 1'b0, chg_active_i = 1'b0, vin_low_i = 1'b0, vin_ok_i = 1'b1;
   logic vin_ovp_i = 1'b0, bat_ovp_i = 1'b0, pwm_pulse_i = 1'b0;
   logic [1:0] stat_o;
   logic [2:0] fault_o;
   logic stat_pull_o, chg_en_o, in_sw_en_o;

   int tests = 0;
   int fails = 0;

   always #(CLK_PER/2) clk = ~clk;

   chgsup_top #(.RESTART_CYC(RST), .BAT_TMO(TMO), .PULSE_CYC(PUL)) uut (
      .clk(clk), .rst_n(rst_n), .stat_en_i(stat_en_i), .chg_active_i(chg_active_i),
      .vin_low_i(vin_low_i), .vin_ok_i(vin_ok_i), .vin_ovp_i(vin_ovp_i),
      .bat_ovp_i(bat_ovp_i), .pwm_pulse_i(pwm_pulse_i), .stat_o(stat_o),
      .fault_o(fault_o), .stat_pull_o(stat_pull_o), .chg_en_o(chg_en_o),
      .in_sw_en_o(in_sw_en_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(CLK_PER * 5000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      stat_en_i = 1'b1;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1;
      chk("R11 chg_en", chg_en_o, 1);
      chk("R11 sw_en", in_sw_en_o, 1);
      chk("R11 fault", fault_o, 0);
      chk("R11 pull", stat_pull_o, 0);
      chk("R7 idle stat", stat_o, 0);

      chg_active_i = 1'b1; #1;
      chk("R7 charging stat", stat_o, 1);
      chk("R7 charging pull", stat_pull_o, 1);
      stat_en_i = 1'b0; #1;
      chk("R6 pin disabled", stat_pull_o, 0);
      stat_en_i = 1'b1;

      // input-low while not charging is ignored
      chg_active_i = 1'b0; vin_low_i = 1'b1;
      tick();
      chk("R12 not charging chg_en", chg_en_o, 1);
      chk("R12 not charging fault", fault_o, 0);
      chk("R12 not charging pull", stat_pull_o, 0);
      vin_low_i = 1'b0;

      // input-low fault, input stays invalid past the interval
      chg_active_i = 1'b1; vin_ok_i = 1'b0; vin_low_i = 1'b1;
      tick();
      vin_low_i = 1'b0; #1;
      chk("R1 chg_en", chg_en_o, 0);
      chk("R1 fault", fault_o, 3);
      chk("R1 stat", stat_o, 3);
      chk("R8 pulse k0", stat_pull_o, 1);
      for (int k = 1; k <= RST + 3; k++) begin
         tick();
         chk("R8 pulse window", stat_pull_o, (k < PUL) ? 1 : 0);
         chk("R2 waits for valid input", chg_en_o, 0);
      end
      vin_ok_i = 1'b1;
      tick();
      chk("R2 restart on valid input", chg_en_o, 1);
      chk("R7 back to charging", stat_o, 1);

      // exact restart timing, with input-low held during the fault
      vin_low_i = 1'b1;
      tick();
      chk("R1 second entry", chg_en_o, 0);
      for (int k = 1; k <= RST + 1; k++) begin
         tick();
         chk("R2 exact restart edge", chg_en_o, (k >= RST + 1) ? 1 : 0);
         if (k <= RST) begin
            chk("R12 held fault code", fault_o, 3);
            if (k >= PUL) chk("R12 no new pulse", stat_pull_o, 0);
         end
         if (k == RST) vin_low_i = 1'b0;
      end

      // overvoltage and input-low together
      vin_low_i = 1'b1; vin_ovp_i = 1'b1;
      tick();
      vin_low_i = 1'b0; #1;
      chk("R10 ov wins", fault_o, 1);
      chk("R3 sw off", in_sw_en_o, 0);
      chk("R3 chg off", chg_en_o, 0);
      chk("R3 stat", stat_o, 3);
      chk("R8 ov pulse", stat_pull_o, 1);
      repeat (3) tick();
      chk("R4 held while ov", in_sw_en_o, 0);
      vin_ovp_i = 1'b0; vin_ok_i = 1'b0;
      tick();
      chk("R4 needs valid input", in_sw_en_o, 0);
      vin_ok_i = 1'b1;
      tick();
      chk("R4 sw back", in_sw_en_o, 1);
      chk("R4 chg back", chg_en_o, 1);
      repeat (PUL) tick();

      // new fault during pulse restarts it
      vin_low_i = 1'b1;
      tick();
      vin_low_i = 1'b0;
      tick();
      tick();
      vin_ovp_i = 1'b1;
      tick();
      chk("R9 code overwritten", fault_o, 1);
      repeat (PUL - 1) tick();
      chk("R9 pulse extended", stat_pull_o, 1);
      tick();
      chk("R8 released during fault", stat_pull_o, 0);
      vin_ovp_i = 1'b0;
      tick();
      repeat (PUL) tick();
      chk("R7 charging after recovery", stat_o, 1);

      // battery overvoltage with quiet PWM
      bat_ovp_i = 1'b1; pwm_pulse_i = 1'b0;
      repeat (TMO - 1) tick();
      chk("R5 before timeout stat", stat_o, 1);
      chk("R5 before timeout fault", fault_o, 1);
      pwm_pulse_i = 1'b1;
      tick();
      pwm_pulse_i = 1'b0;
      repeat (TMO - 1) tick();
      chk("R5 pulse restarted count", stat_o, 1);
      tick();
      chk("R5 timeout fault", fault_o, 4);
      chk("R5 timeout stat", stat_o, 3);
      chk("R5 charge unaffected", chg_en_o, 1);
      chk("R8 bat pulse", stat_pull_o, 1);
      pwm_pulse_i = 1'b1;
      tick();
      chk("R5 cleared by pwm", stat_o, 1);
      chk("R5 code kept", fault_o, 4);
      pwm_pulse_i = 1'b0; bat_ovp_i = 1'b0;
      tick();

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule